// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns 8-bit bytes, or 9-bit words, into asynchronous NRZ frames on a single output line. A frame is a low start bit, the data bits sent least significant first, and a high stop bit. When the optional ninth bit is enabled, it is supplied by the host next to the byte. A host write lands in a holding register. A separate shift register drives the line. The holding register passes its word to the shift register only once the stop bit of the frame in progress has finished, so the host can queue the next word while the current one is still being sent.

Two flags report progress. The holding-empty flag is set each time a word moves into the shift register, and an interrupt enable can gate it onto an interrupt output. The shift-empty flag shows that no frame is on the line and has no interrupt. Bit timing comes from an external baud tick, one tick per bit period. A polarity input selects whether the line idles high or low, and the whole waveform is inverted when idle-low is chosen. Clearing the transmit enable aborts any frame in progress.

Top module: `serial_tx_dbuf`

## Requirements
- R1: With the line idling high, a frame is a 0 start bit, then the DATA_W data bits with bit 0 first, then a 1 stop bit. The line shows the start level two clocks after the word is written while the shifter is idle.
- R2: When `nine_bit_mode` is 1 at load time, the word `wr_bit9` latched with the byte is sent as an extra data bit after the DATA_W byte bits and before the stop bit.
- R3: With `idle_high` = 0, every level on `tx_line` (idle, start, data, stop) is the inverse of the level it has with `idle_high` = 1.
- R4: The frame advances exactly one bit per clock cycle in which `baud_tick` is 1. While no frame is in progress, `tx_line` stays at the idle level.
- R5: A word written while a frame is being sent is loaded on the tick that ends that frame's stop bit. Its start bit follows the stop bit with no idle gap.
- R6: `hold_empty` does not fall on the clock after a write is taken; it reads 0 from the second clock after the write edge onward.
- R7: `hold_empty` is set one clock after a word moves from the holding register into the shift register.
- R8: While `tx_en` is 0, `hold_empty` is 0 and writes are ignored. Raising `tx_en` sets `hold_empty` on the next clock.
- R9: `shift_empty` is 1 while no frame is in progress and 0 from the load of a frame until its stop bit ends.
- R10: `irq` is `hold_empty` gated by `irq_en`, registered one clock. `hold_empty` is set regardless of `irq_en`.
- R11: Clearing `tx_en` during a frame aborts it: within two clocks the line is at the idle level, `shift_empty` is 1 and `hold_empty` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; 0 aborts and empties both registers |
| nine_bit_mode | input | 1 | 1 sends the ninth data bit |
| idle_high | input | 1 | 1: line idles high; 0: whole waveform inverted |
| irq_en | input | 1 | Interrupt enable for the holding-empty flag |
| wr_valid | input | 1 | Write strobe into the holding register |
| wr_data | input | DATA_W | Data byte to send |
| wr_bit9 | input | 1 | Ninth bit, latched with `wr_data` |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_line | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register is free for a new word |
| shift_empty | output | 1 | No frame in progress |
| irq | output | 1 | Interrupt: `hold_empty` and `irq_en` |

## Verification
The hardest situation to reach is the seamless hand-over, where a queued word is waiting at the exact tick that ends a stop bit. The stimulus loads one word and waits until it sits in the shifter. It then writes a second word before issuing any baud tick, which also exposes the two-cycle lag of the holding-empty flag against a busy shifter. Only then does it step the ticks through the first frame, and it checks that the line goes straight from the stop level to the next start level. Aborting is reached by dropping the enable two bits into a frame of all zeros, so that a line left low would show.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } stx_state_e;
endpackage

// File: rtl/stx_holding.sv
module stx_holding #(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            irq_en,
  input  logic            wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic            wr_bit9,
  input  logic            take,
  output logic            full,
  output logic [DATA_W:0] word,
  output logic            empty_flag,
  output logic            irq
);
  logic            full_q;
  logic [DATA_W:0] word_q;
  logic            flag_q;
  logic            irq_q;

  // Occupancy and stored word; a write at the take edge refills at once.
  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else if (!en) begin
      full_q <= 1'b0;
    end else if (wr_valid) begin
      full_q <= 1'b1;
      word_q <= {wr_bit9, wr_data};
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  // Flag follows occupancy one clock later, giving the two-cycle view.
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= en && !full_q;
      irq_q  <= irq_en && en && !full_q;
    end
  end

  assign full       = full_q;
  assign word       = word_q;
  assign empty_flag = flag_q;
  assign irq        = irq_q;

  p_write_fills_r6: assert property (@(posedge clk) disable iff (rst)
    (en && wr_valid) |=> full_q);
  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q);
  p_disabled_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!full_q && !flag_q));
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            tick,
  input  logic            nine_mode,
  input  logic            hold_full,
  input  logic [DATA_W:0] hold_word,
  output logic            take,
  output logic            level,
  output logic            busy
);
  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  stx_state_e        state_q;
  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  idx_q;
  logic              nine_q;
  logic              busy_q;
  logic [CNT_W-1:0]  last_idx;
  logic              frame_end;

  assign last_idx  = nine_q ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
  assign frame_end = (state_q == ST_STOP) && tick;
  assign take      = en && hold_full && ((state_q == ST_IDLE) || frame_end);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
      nine_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else if (take) begin
      state_q <= ST_START;
      shreg_q <= hold_word;
      idx_q   <= '0;
      nine_q  <= nine_mode;
      busy_q  <= 1'b1;
    end else if (tick) begin
      case (state_q)
        ST_START: state_q <= ST_DATA;
        ST_DATA: begin
          if (idx_q == last_idx) begin
            state_q <= ST_STOP;
          end else begin
            shreg_q <= shreg_q >> 1;
            idx_q   <= idx_q + 1'b1;
          end
        end
        ST_STOP: begin
          state_q <= ST_IDLE;
          busy_q  <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_START: level = 1'b0;
      ST_DATA:  level = shreg_q[0];
      default:  level = 1'b1;
    endcase
  end

  assign busy = busy_q;

  p_load_when_free_r5: assert property (@(posedge clk) disable iff (rst)
    take |-> ((state_q == ST_IDLE) || (state_q == ST_STOP && tick)));
  p_start_after_load_r1: assert property (@(posedge clk) disable iff (rst)
    take |=> (state_q == ST_START));
  p_abort_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (state_q == ST_IDLE && !busy_q));
  p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !tick && state_q != ST_IDLE) |=> $stable(state_q));
  p_index_bound_r2: assert property (@(posedge clk) disable iff (rst)
    idx_q <= CNT_W'(DATA_W));
  p_busy_state_r9: assert property (@(posedge clk) disable iff (rst)
    busy_q == (state_q != ST_IDLE));
endmodule

// File: rtl/stx_line.sv
module stx_line (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic idle_high,
  output logic line
);
  logic line_q;

  // Idle-high passes the mark level; idle-low inverts the whole waveform.
  always_ff @(posedge clk) begin
    if (rst) line_q <= idle_high;
    else     line_q <= idle_high ? level : !level;
  end

  assign line = line_q;
endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              nine_bit_mode,
  input  logic              idle_high,
  input  logic              irq_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              baud_tick,
  output logic              tx_line,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              irq
);
  logic            hold_full;
  logic [DATA_W:0] hold_word;
  logic            take;
  logic            level;
  logic            busy;

  stx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .en(tx_en), .irq_en(irq_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_bit9(wr_bit9),
    .take(take), .full(hold_full), .word(hold_word),
    .empty_flag(hold_empty), .irq(irq)
  );

  stx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .en(tx_en), .tick(baud_tick),
    .nine_mode(nine_bit_mode), .hold_full(hold_full), .hold_word(hold_word),
    .take(take), .level(level), .busy(busy)
  );

  stx_line u_line (
    .clk(clk), .rst(rst), .level(level), .idle_high(idle_high), .line(tx_line)
  );

  assign shift_empty = !busy;

  p_idle_level_r3: assert property (@(posedge clk) disable iff (rst)
    (shift_empty && $past(shift_empty)) |-> (tx_line == $past(idle_high)));
  p_take_empties_r7: assert property (@(posedge clk) disable iff (rst)
    (take && !wr_valid && tx_en) |=> !hold_full);
endmodule

// File: tb/tb_serial_tx_dbuf.sv
module tb_serial_tx_dbuf;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, nine_bit_mode = 1'b0, idle_high = 1'b1, irq_en = 1'b0;
  logic wr_valid = 1'b0, wr_bit9 = 1'b0, baud_tick = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic tx_line, hold_empty, shift_empty, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_tx_dbuf #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .nine_bit_mode(nine_bit_mode),
    .idle_high(idle_high), .irq_en(irq_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_bit9(wr_bit9), .baud_tick(baud_tick),
    .tx_line(tx_line), .hold_empty(hold_empty), .shift_empty(shift_empty),
    .irq(irq)
  );

  // {idle_high, nine_bit_mode, bit9, data}
  localparam logic [10:0] VEC [6] = '{
    {1'b1, 1'b0, 9'h0A5},
    {1'b1, 1'b0, 9'h001},
    {1'b1, 1'b1, 9'h13C},
    {1'b1, 1'b1, 9'h0FF},
    {1'b0, 1'b0, 9'h0C3},
    {1'b0, 1'b1, 9'h155}
  };

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_tick();
    baud_tick = 1'b1;
    step();
    baud_tick = 1'b0;
    step();
  endtask

  task automatic write_word(logic [8:0] w);
    wr_valid = 1'b1;
    wr_data  = w[7:0];
    wr_bit9  = w[8];
    step();
    wr_valid = 1'b0;
  endtask

  // Mark level of position k: 0 start, 1..n data, n+1 stop.
  function automatic logic mark_bit(logic [8:0] w, logic nine, int k);
    int n = nine ? 9 : 8;
    if (k == 0) return 1'b0;
    if (k > n)  return 1'b1;
    return w[k-1];
  endfunction

  function automatic logic on_line(logic m, logic ih);
    return ih ? m : !m;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step();
    // Reset state
    check("R8 reset hold_empty", hold_empty, 1'b0);
    check("R9 reset shift_empty", shift_empty, 1'b1);
    check("R4 reset line idle", tx_line, 1'b1);
    check("R10 reset irq", irq, 1'b0);

    tx_en = 1'b1;
    step();
    check("R8 enable sets hold_empty", hold_empty, 1'b1);
    check("R10 flag set with irq_en low", irq, 1'b0);
    irq_en = 1'b1;
    step();
    check("R10 irq follows enable", irq, 1'b1);
    irq_en = 1'b0;
    step();
    check("R10 irq drops with enable", irq, 1'b0);

    // Table-driven frames
    for (int v = 0; v < 6; v++) begin
      logic ih, nn;
      logic [8:0] w;
      string req;
      int n;
      ih = VEC[v][10];
      nn = VEC[v][9];
      w  = VEC[v][8:0];
      n  = nn ? 9 : 8;
      req = !ih ? "R3" : (nn ? "R2" : "R1");
      idle_high = ih;
      nine_bit_mode = nn;
      step(2);
      check("R4 idle level", tx_line, ih);
      check("R9 idle shift_empty", shift_empty, 1'b1);
      write_word(w);
      step(2);
      check("R7 flag after load", hold_empty, 1'b1);
      check("R9 busy during frame", shift_empty, 1'b0);
      check(req, tx_line, on_line(1'b0, ih));
      for (int k = 1; k <= n + 1; k++) begin
        send_tick();
        check(req, tx_line, on_line(mark_bit(w, nn, k), ih));
      end
      send_tick();
      check("R4 idle after stop", tx_line, ih);
      check("R9 empty after stop", shift_empty, 1'b1);
    end

    // Back-to-back hand-over
    idle_high = 1'b1;
    nine_bit_mode = 1'b0;
    step(2);
    write_word(9'h05A);
    step(2);
    wr_valid = 1'b1;
    wr_data  = 8'h81;
    wr_bit9  = 1'b0;
    step();
    wr_valid = 1'b0;
    check("R6 flag still set one clock after write", hold_empty, 1'b1);
    step();
    check("R6 flag clear two clocks after write", hold_empty, 1'b0);
    check("R1 start of first word", tx_line, 1'b0);
    for (int k = 1; k <= 9; k++) begin
      send_tick();
      check("R1 first word", tx_line, mark_bit(9'h05A, 1'b0, k));
    end
    send_tick();
    check("R5 no gap before second start", tx_line, 1'b0);
    check("R7 flag after hand-over", hold_empty, 1'b1);
    check("R5 still busy", shift_empty, 1'b0);
    for (int k = 1; k <= 9; k++) begin
      send_tick();
      check("R5 second word", tx_line, mark_bit(9'h081, 1'b0, k));
    end
    send_tick();
    check("R4 idle after pair", tx_line, 1'b1);

    // Ticks with no frame leave the line idle
    send_tick();
    send_tick();
    check("R4 ticks while idle", tx_line, 1'b1);

    // Abort mid-frame
    write_word(9'h000);
    step(2);
    send_tick();
    send_tick();
    check("R11 line low in data", tx_line, 1'b0);
    tx_en = 1'b0;
    step(2);
    check("R11 line idle after abort", tx_line, 1'b1);
    check("R11 shift_empty after abort", shift_empty, 1'b1);
    check("R11 hold_empty after abort", hold_empty, 1'b0);

    // Writes while disabled are ignored
    write_word(9'h000);
    step();
    tx_en = 1'b1;
    step();
    check("R8 hold_empty after re-enable", hold_empty, 1'b1);
    step(2);
    check("R8 ignored write starts nothing", shift_empty, 1'b1);
    check("R8 ignored write line idle", tx_line, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule